// File: doc/BRIEF.md
# Retina-Locked Modulator State Addressing

This block keeps the accumulated error of a delta-sigma display modulator attached to the tracked image instead of to the panel pixels. It decodes a two-channel quadrature position encoder into a signed one-dimensional position, and maintains a copy of that position reduced modulo the state memory depth. At the start of each scanned row it takes a snapshot of both values. For every pixel index presented during that row, it forms the state memory address by adding the snapshot offset to the index, modulo the depth.

The same address serves the read and the later write-back of a pixel's state. As a result, the error of a pixel that the viewer is tracking follows the image as the panel moves. The state memory and the pixel source sit outside the block. The depth defaults to one entry per scanned row position (540).

Top module: `tracker_state_addr`

## Requirements
- R1: After reset, pos_o and row_pos_o read 0, step_err_o reads 0 and addr_o equals pix_idx_i.
- R2: The encoder pair {A,B} steps forward through the order 00, 01, 11, 10, 00. Each single-bit change in the forward direction adds 1 to pos_o, and each single-bit change in the reverse direction subtracts 1. The change appears on pos_o after the third rising clock edge following the input change: two synchroniser stages, then the position register.
- R3: When both A and B change together (00<->11 or 01<->10), pos_o is left unchanged and step_err_o pulses high for exactly one cycle, on the same edge at which a valid step would have updated pos_o. Later steps are decoded relative to the new encoder state.
- R4: A cycle with row_start_i high loads row_pos_o, on that clock edge, with the pos_o value present before the edge. row_pos_o holds its value in every other cycle.
- R5: addr_o = (pix_idx_i + (row_pos_o mod DEPTH)) mod DEPTH, with the mod result always taken in 0..DEPTH-1. addr_o follows pix_idx_i combinationally, and pix_idx_i is below DEPTH.
- R6: Negative positions wrap, so position -1 gives offset DEPTH-1, and a position of exactly k*DEPTH gives offset 0 (addr_o = pix_idx_i).
- R7: Encoder movement during a row changes pos_o but neither row_pos_o nor addr_o until the next row_start_i. Every access within one row therefore sees the same offset, and the read and the write of a pixel land on the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_a_i | input | 1 | Encoder channel A (asynchronous) |
| enc_b_i | input | 1 | Encoder channel B (asynchronous) |
| row_start_i | input | 1 | One-cycle pulse at the start of each scanned row |
| pix_idx_i | input | $clog2(DEPTH) | Pixel index along the scanned line |
| pos_o | output | POS_W | Live signed encoder position |
| row_pos_o | output | POS_W | Signed position latched at the last row start |
| addr_o | output | $clog2(DEPTH) | State memory address for read and write-back |
| step_err_o | output | 1 | One-cycle flag for an ignored double transition |

## Verification
A wrong decode of a single step shows on pos_o three edges after the encoder edge, and it never heals, because every later position carries the error. A drift between the modulo offset and the signed position stays hidden on pos_o. It does show on addr_o once the next row start has latched it, and it appears only at positions that are not multiples of the depth. For that reason the address is swept over every pixel index at positions on both sides of zero, across several wraps. A missed or spurious row latch shows at once on row_pos_o and on every address of that row.

// File: rtl/trk_pkg.sv
package trk_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;

  function automatic step_e classify(input logic [1:0] prev, input logic [1:0] cur);
    unique case ({prev, cur})
      4'b00_01, 4'b01_11, 4'b11_10, 4'b10_00: return STEP_UP;
      4'b01_00, 4'b11_01, 4'b10_11, 4'b00_10: return STEP_DN;
      4'b00_11, 4'b11_00, 4'b01_10, 4'b10_01: return STEP_BAD;
      default:                                return STEP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/trk_quad_sync.sv
module trk_quad_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/trk_quad_decode.sv
module trk_quad_decode
  import trk_pkg::*;
#(
  parameter int DEPTH = 540,
  parameter int POS_W = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              ab_i,
  output logic signed [POS_W-1:0] pos_o,
  output logic [AW-1:0]           off_o,
  output logic                    err_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [1:0]              prev_q;
  logic signed [POS_W-1:0] pos_q;
  logic [AW-1:0]           off_q;
  logic                    err_q;
  step_e                   step;

  assign step = classify(prev_q, ab_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 2'b00;
      pos_q  <= '0;
      off_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      prev_q <= ab_i;
      err_q  <= (step == STEP_BAD);
      if (step == STEP_UP) begin
        pos_q <= pos_q + 1'b1;
        off_q <= (off_q == LAST) ? '0 : off_q + 1'b1;
      end else if (step == STEP_DN) begin
        pos_q <= pos_q - 1'b1;
        off_q <= (off_q == '0) ? LAST : off_q - 1'b1;
      end
    end
  end

  assign pos_o = pos_q;
  assign off_o = off_q;
  assign err_o = err_q;

  assert_unit_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q != $past(pos_q)) |->
      ((pos_q - $past(pos_q) == POS_W'(1)) || ($past(pos_q) - pos_q == POS_W'(1))));

  assert_bad_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (pos_q == $past(pos_q) && off_q == $past(off_q)));

  assert_off_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q <= LAST);
endmodule

// File: rtl/trk_row_addr.sv
module trk_row_addr #(
  parameter int DEPTH = 540,
  parameter int POS_W = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    row_start_i,
  input  logic signed [POS_W-1:0] pos_i,
  input  logic [AW-1:0]           off_i,
  input  logic [AW-1:0]           pix_i,
  output logic signed [POS_W-1:0] row_pos_o,
  output logic [AW-1:0]           addr_o
);
  localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

  logic signed [POS_W-1:0] row_pos_q;
  logic [AW-1:0]           row_off_q;
  logic [AW:0]             sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_pos_q <= '0;
      row_off_q <= '0;
    end else if (row_start_i) begin
      row_pos_q <= pos_i;
      row_off_q <= off_i;
    end
  end

  // both operands are below DEPTH, so one conditional subtract suffices
  assign sum    = {1'b0, pix_i} + {1'b0, row_off_q};
  assign addr_o = (sum >= DEPTH_L) ? AW'(sum - DEPTH_L) : sum[AW-1:0];
  assign row_pos_o = row_pos_q;

  assert_row_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_start_i |=> $stable(row_pos_q));

  assert_row_off_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_start_i |=> $stable(row_off_q));

  assert_addr_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, pix_i} < DEPTH_L) |-> ({1'b0, addr_o} < DEPTH_L));
endmodule

// File: rtl/tracker_state_addr.sv
module tracker_state_addr #(
  parameter int DEPTH      = 540,
  parameter int POS_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          enc_a_i,
  input  logic                          enc_b_i,
  input  logic                          row_start_i,
  input  logic [$clog2(DEPTH)-1:0]      pix_idx_i,
  output logic signed [POS_W-1:0]       pos_o,
  output logic signed [POS_W-1:0]       row_pos_o,
  output logic [$clog2(DEPTH)-1:0]      addr_o,
  output logic                          step_err_o
);
  localparam int AW = $clog2(DEPTH);

  logic [1:0]              ab_sync;
  logic signed [POS_W-1:0] pos;
  logic [AW-1:0]           off;

  trk_quad_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({enc_a_i, enc_b_i}),
    .q_o    (ab_sync)
  );

  trk_quad_decode #(.DEPTH(DEPTH), .POS_W(POS_W)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ab_i   (ab_sync),
    .pos_o  (pos),
    .off_o  (off),
    .err_o  (step_err_o)
  );

  trk_row_addr #(.DEPTH(DEPTH), .POS_W(POS_W)) u_row (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .row_start_i (row_start_i),
    .pos_i       (pos),
    .off_i       (off),
    .pix_i       (pix_idx_i),
    .row_pos_o   (row_pos_o),
    .addr_o      (addr_o)
  );

  assign pos_o = pos;
endmodule

// File: tb/tracker_state_addr_test.sv
module tracker_state_addr_test;
  localparam int DEPTH = 12;
  localparam int POS_W = 8;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, row_start = 1'b0;
  logic [AW-1:0] pix = '0;
  logic signed [POS_W-1:0] pos_o, row_pos_o;
  logic [AW-1:0] addr_o;
  logic step_err_o;

  int n_run = 0, n_fail = 0;
  int m_pos = 0;
  int m_row = 0;
  int seq_i = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tracker_state_addr #(.DEPTH(DEPTH), .POS_W(POS_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .enc_a_i(enc_a), .enc_b_i(enc_b),
    .row_start_i(row_start), .pix_idx_i(pix), .pos_o(pos_o),
    .row_pos_o(row_pos_o), .addr_o(addr_o), .step_err_o(step_err_o)
  );

  function automatic logic [1:0] gray(input int i);
    case (((i % 4) + 4) % 4)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic move(input int dir);
    seq_i += dir;
    @(negedge clk);
    {enc_a, enc_b} = gray(seq_i);
    repeat (3) @(negedge clk);
    m_pos += dir;
  endtask

  task automatic latch_row();
    @(negedge clk);
    row_start = 1'b1;
    @(negedge clk);
    row_start = 1'b0;
    m_row = m_pos;
    check("R4 row_pos", int'(row_pos_o), m_row);
  endtask

  task automatic sweep_addr(input string req);
    for (int p = 0; p < DEPTH; p++) begin
      pix = AW'(p);
      #1;
      check(req, int'(addr_o), (((p + m_row) % DEPTH) + DEPTH) % DEPTH);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 pos", int'(pos_o), 0);
    check("R1 row_pos", int'(row_pos_o), 0);
    check("R1 err", int'(step_err_o), 0);
    pix = AW'(7); #1;
    check("R1 addr", int'(addr_o), 7);

    // R2 latency: change visible only after third edge
    seq_i = 1;
    @(negedge clk);
    {enc_a, enc_b} = gray(seq_i);
    repeat (2) @(negedge clk);
    check("R2 latency before", int'(pos_o), 0);
    @(negedge clk);
    check("R2 latency after", int'(pos_o), 1);
    m_pos = 1;

    // R2 forward and R5 address sweep
    for (int k = 0; k < 30; k++) begin
      move(1);
      check("R2 fwd", int'(pos_o), m_pos);
      if (k % 5 == 0) begin latch_row(); sweep_addr("R5 addr fwd"); end
    end
    // R2 reverse into negatives, R6 wrap
    for (int k = 0; k < 70; k++) begin
      move(-1);
      check("R2 rev", int'(pos_o), m_pos);
      if (k % 3 == 0) begin latch_row(); sweep_addr("R6 addr wrap"); end
    end
    // R6 exact multiples of depth
    while (m_pos != -24) move(m_pos < -24 ? 1 : -1);
    latch_row();
    sweep_addr("R6 multiple");
    while (m_pos != -1) move(1);
    latch_row();
    pix = '0; #1;
    check("R6 minus one", int'(addr_o), DEPTH - 1);

    // R3 double transition ignored
    @(negedge clk);
    {enc_a, enc_b} = ~gray(seq_i);
    seq_i += 2;
    repeat (2) @(negedge clk);
    check("R3 err early", int'(step_err_o), 0);
    @(negedge clk);
    check("R3 err pulse", int'(step_err_o), 1);
    check("R3 pos held", int'(pos_o), m_pos);
    @(negedge clk);
    check("R3 err clears", int'(step_err_o), 0);
    move(1);
    check("R3 resume fwd", int'(pos_o), m_pos);
    move(-1);
    move(-1);
    check("R3 resume rev", int'(pos_o), m_pos);

    // R7 movement inside a row leaves offset alone
    latch_row();
    for (int k = 0; k < 5; k++) move(1);
    check("R7 pos moved", int'(pos_o), m_pos);
    check("R7 row_pos held", int'(row_pos_o), m_row);
    sweep_addr("R7 addr held");
    latch_row();
    sweep_addr("R7 new row");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(negedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule